// File: doc/BRIEF.md
# Fetch Address Sequencer with Two-Entry Return Stack

This block produces the instruction fetch address for a small 8-bit controller whose instructions are 14 bits wide and whose program space holds 512 words. The program counter is 10 bits wide and is handled as three segments: a top bit (bit 9), a page bit (bit 8) and a low byte (bits 7..0). Each segment picks its own source for every instruction. The source depends on the operation class supplied by the decoder.

A call saves the address of the following instruction on a two-entry hardware return stack, and a return takes it back. Short transfers do not encode the page bit. They take it from a general-purpose status bit supplied on `page_bit`. A write to the counter register, which software sees at register address 02, takes its low byte from the ALU result.

One operation is applied on every clock edge. The fetch address and the overflow flag both come straight from registers.

Top module: `fetch_pc_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next `fetch_addr` is 0x1FF (the last program word) and `stk_ovf` is 0. The stack count returns to empty and every stack entry returns to 0x000.
- R2: The operation codes on `op` are: 0 step, 1 counter write, 2 short jump, 3 short call, 4 long jump, 5 long call, 6 return, 7 return-with-W. On a step, bits 8..0 increment by one and wrap from 0x1FF to 0x000, and bit 9 keeps its value.
- R3: A counter write loads bit 9 = 0, bit 8 = `page_bit` and bits 7..0 = `alu_res`.
- R4: A short jump loads bit 9 = `imm_addr[9]`, bit 8 = `page_bit` and bits 7..0 = `imm_addr[7:0]`. The value of `imm_addr[8]` is ignored.
- R5: A short call loads bit 9 = 0, bit 8 = `page_bit` and bits 7..0 = `imm_addr[7:0]`. It pushes the step value of the current address.
- R6: A long jump loads all 10 bits from `imm_addr`.
- R7: A long call loads all 10 bits from `imm_addr` and pushes the step value of the current address.
- R8: Return and return-with-W both load the full address from the newest stack entry and pop it.
- R9: Two nested calls return in last-in, first-out order.
- R10: A push while both entries are occupied drops the older entry and sets `stk_ovf`. `stk_ovf` then stays at 1 until reset, and it stays 0 after exactly two pushes.
- R11: A return with the stack empty reloads the newest entry without changing the stack. That entry is the address most recently returned to, or 0x000 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation class of the current instruction |
| imm_addr | input | 10 | Address field of the instruction word |
| alu_res | input | 8 | ALU result used by a counter write |
| page_bit | input | 1 | Status page bit used by short transfers and counter writes |
| fetch_addr | output | 10 | Registered program counter (fetch address) |
| stk_ovf | output | 1 | Sticky flag, set when a push overwrites an entry |

## Verification
The operation classes are applied with address fields whose bit 9 and bit 8 differ from the page bit and from the current counter. This shows whether each segment really follows its own source rule rather than a shared one. Step operations are placed at 0x1FF and 0x3FF to separate a 9-bit wrap from a 10-bit wrap. Call and return chains that are one, two and three deep separate correct LIFO order, the overwrite of the older entry and the sticky flag from an early or missing overflow. Returns on an empty stack, both after a drained chain and straight after reset, pin down the value that gets reloaded.

// File: rtl/fetch_pc_pkg.sv
package fetch_pc_pkg;

  typedef enum logic [2:0] {
    PC_OP_STEP  = 3'd0,
    PC_OP_WRITE = 3'd1,
    PC_OP_SJMP  = 3'd2,
    PC_OP_SCALL = 3'd3,
    PC_OP_LJMP  = 3'd4,
    PC_OP_LCALL = 3'd5,
    PC_OP_RET   = 3'd6,
    PC_OP_RETW  = 3'd7
  } pc_op_e;

  function automatic logic op_pushes(pc_op_e o);
    return (o == PC_OP_SCALL) || (o == PC_OP_LCALL);
  endfunction

  function automatic logic op_pops(pc_op_e o);
    return (o == PC_OP_RET) || (o == PC_OP_RETW);
  endfunction

endpackage

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import fetch_pc_pkg::*;
#(
  parameter int LO_W = 8,
  localparam int PC_W = LO_W + 2
) (
  input  pc_op_e            op,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [PC_W-1:0]   imm,
  input  logic [LO_W-1:0]   alu,
  input  logic              page,
  input  logic [PC_W-1:0]   stk_top,
  output logic [PC_W-1:0]   nxt_pc,
  output logic [PC_W-1:0]   step_pc
);

  localparam int MID = LO_W;
  localparam int TOP = LO_W + 1;

  logic [LO_W:0] inc;
  logic          seg_top;
  logic          seg_mid;
  logic [LO_W-1:0] seg_lo;

  assign inc     = cur_pc[LO_W:0] + 1'b1;
  assign step_pc = {cur_pc[TOP], inc};

  // Bit 9 source
  always_comb begin
    unique case (op)
      PC_OP_STEP:                         seg_top = cur_pc[TOP];
      PC_OP_WRITE, PC_OP_SCALL:           seg_top = 1'b0;
      PC_OP_SJMP, PC_OP_LJMP, PC_OP_LCALL: seg_top = imm[TOP];
      default:                            seg_top = stk_top[TOP];
    endcase
  end

  // Bit 8 source
  always_comb begin
    unique case (op)
      PC_OP_STEP:                           seg_mid = inc[LO_W];
      PC_OP_WRITE, PC_OP_SJMP, PC_OP_SCALL: seg_mid = page;
      PC_OP_LJMP, PC_OP_LCALL:              seg_mid = imm[MID];
      default:                              seg_mid = stk_top[MID];
    endcase
  end

  // Bits 7..0 source
  always_comb begin
    unique case (op)
      PC_OP_STEP:  seg_lo = inc[LO_W-1:0];
      PC_OP_WRITE: seg_lo = alu;
      PC_OP_SJMP, PC_OP_SCALL, PC_OP_LJMP, PC_OP_LCALL:
                   seg_lo = imm[LO_W-1:0];
      default:     seg_lo = stk_top[LO_W-1:0];
    endcase
  end

  assign nxt_pc = {seg_top, seg_mid, seg_lo};

endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int W     = 10,
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_val,
  output logic [W-1:0] top,
  output logic         ovf
);

  logic [W-1:0]     ent [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic             full;
  logic             shift_up;

  assign full     = (cnt == CNT_W'(DEPTH));
  assign shift_up = pop && (cnt > CNT_W'(1));
  assign top      = ent[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam int DN = (i > 0) ? i - 1 : 0;
    localparam int UP = (i + 1 < DEPTH) ? i + 1 : i;
    always_ff @(posedge clk) begin
      if (rst) begin
        ent[i] <= '0;
      end else if (push) begin
        ent[i] <= (i == 0) ? push_val : ent[DN];
      end else if (shift_up) begin
        ent[i] <= ent[UP];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (push) begin
        if (full) ovf <= 1'b1;
        else      cnt <= cnt + 1'b1;
      end else if (pop && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/fetch_pc_ctrl.sv
module fetch_pc_ctrl
  import fetch_pc_pkg::*;
#(
  parameter int               LO_W    = 8,
  parameter int               STK_DEP = 2,
  parameter logic [LO_W+1:0]  RST_VEC = 10'h1FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op,
  input  logic [LO_W+1:0]   imm_addr,
  input  logic [LO_W-1:0]   alu_res,
  input  logic              page_bit,
  output logic [LO_W+1:0]   fetch_addr,
  output logic              stk_ovf
);

  localparam int PC_W = LO_W + 2;

  pc_op_e          op_e;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] step_pc;
  logic [PC_W-1:0] stk_top;

  assign op_e = pc_op_e'(op);

  pc_next_sel #(.LO_W(LO_W)) u_sel (
    .op      (op_e),
    .cur_pc  (pc_q),
    .imm     (imm_addr),
    .alu     (alu_res),
    .page    (page_bit),
    .stk_top (stk_top),
    .nxt_pc  (pc_d),
    .step_pc (step_pc)
  );

  pc_ret_stack #(.W(PC_W), .DEPTH(STK_DEP)) u_stk (
    .clk      (clk),
    .rst      (rst),
    .push     (op_pushes(op_e)),
    .pop      (op_pops(op_e)),
    .push_val (step_pc),
    .top      (stk_top),
    .ovf      (stk_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RST_VEC;
    else     pc_q <= pc_d;
  end

  assign fetch_addr = pc_q;

endmodule

// File: rtl/fetch_pc_ctrl_chk.sv
module fetch_pc_ctrl_chk #(
  parameter int              LO_W    = 8,
  parameter logic [LO_W+1:0] RST_VEC = 10'h1FF
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      op,
  input logic [LO_W+1:0] imm_addr,
  input logic [LO_W-1:0] alu_res,
  input logic            page_bit,
  input logic [LO_W+1:0] fetch_addr,
  input logic            stk_ovf
);

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (fetch_addr == RST_VEC) && !stk_ovf);

  // R2
  a_r2_step_wrap: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd0) |=> (fetch_addr[LO_W+1] == $past(fetch_addr[LO_W+1])) &&
                     (fetch_addr[LO_W:0] == $past(fetch_addr[LO_W:0]) + 1'b1));

  // R3
  a_r3_write_src: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd1) |=> fetch_addr == {1'b0, $past(page_bit), $past(alu_res)});

  // R4
  a_r4_short_jump: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd2) |=> fetch_addr == {$past(imm_addr[LO_W+1]), $past(page_bit),
                                    $past(imm_addr[LO_W-1:0])});

  // R5
  a_r5_short_call_top: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd3) |=> !fetch_addr[LO_W+1]);

  // R6
  a_r6_long_jump: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd4) |=> fetch_addr == $past(imm_addr));

  // R10
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    stk_ovf |=> stk_ovf);

endmodule

bind fetch_pc_ctrl fetch_pc_ctrl_chk #(.LO_W(LO_W), .RST_VEC(RST_VEC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op         (op),
  .imm_addr   (imm_addr),
  .alu_res    (alu_res),
  .page_bit   (page_bit),
  .fetch_addr (fetch_addr),
  .stk_ovf    (stk_ovf)
);

// File: tb/fetch_pc_ctrl_bench.sv
`timescale 1ns/100ps
module fetch_pc_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op = 3'd0;
  logic [9:0] imm_addr = '0;
  logic [7:0] alu_res = '0;
  logic       page_bit = 1'b0;
  logic [9:0] fetch_addr;
  logic       stk_ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fetch_pc_ctrl u_fetch_pc_ctrl (
    .clk, .rst, .op, .imm_addr, .alu_res, .page_bit, .fetch_addr, .stk_ovf
  );

  // row: {op, imm, alu, page, expected fetch, expected ovf}
  localparam int NROW = 21;
  localparam logic [32:0] TBL [NROW] = '{
    {3'd0, 10'h000, 8'h00, 1'b0, 10'h000, 1'b0}, // 0  R2 wrap 1FF->000
    {3'd0, 10'h000, 8'h00, 1'b0, 10'h001, 1'b0}, // 1  R2
    {3'd1, 10'h3FF, 8'h5A, 1'b1, 10'h15A, 1'b0}, // 2  R3
    {3'd2, 10'h1C3, 8'h00, 1'b0, 10'h0C3, 1'b0}, // 3  R4 imm bit8 ignored
    {3'd3, 10'h3A7, 8'h00, 1'b1, 10'h1A7, 1'b0}, // 4  R5 push 0C4
    {3'd5, 10'h2F0, 8'h00, 1'b0, 10'h2F0, 1'b0}, // 5  R7 push 1A8
    {3'd6, 10'h000, 8'h00, 1'b0, 10'h1A8, 1'b0}, // 6  R8 R9
    {3'd7, 10'h000, 8'h00, 1'b0, 10'h0C4, 1'b0}, // 7  R8 R9 return-with-W
    {3'd6, 10'h000, 8'h00, 1'b0, 10'h0C4, 1'b0}, // 8  R11 empty
    {3'd4, 10'h3FF, 8'h00, 1'b0, 10'h3FF, 1'b0}, // 9  R6
    {3'd0, 10'h000, 8'h00, 1'b1, 10'h200, 1'b0}, // 10 R2 bit9 kept
    {3'd5, 10'h010, 8'h00, 1'b0, 10'h010, 1'b0}, // 11 R7 push 201
    {3'd5, 10'h020, 8'h00, 1'b0, 10'h020, 1'b0}, // 12 R10 two pushes no ovf
    {3'd3, 10'h030, 8'h00, 1'b0, 10'h030, 1'b1}, // 13 R10 overflow
    {3'd6, 10'h000, 8'h00, 1'b0, 10'h021, 1'b1}, // 14 R10 R8
    {3'd6, 10'h000, 8'h00, 1'b0, 10'h011, 1'b1}, // 15 R10 older 201 dropped
    {3'd6, 10'h000, 8'h00, 1'b0, 10'h011, 1'b1}, // 16 R11
    {3'd1, 10'h000, 8'hFF, 1'b0, 10'h0FF, 1'b1}, // 17 R3 R10 sticky
    {3'd0, 10'h000, 8'h00, 1'b0, 10'h100, 1'b1}, // 18 R2 carry to bit8
    {3'd2, 10'h255, 8'h00, 1'b1, 10'h355, 1'b1}, // 19 R4 bit9 from imm
    {3'd0, 10'h000, 8'h00, 1'b0, 10'h356, 1'b1}  // 20 R2
  };

  task automatic check(string req, logic [9:0] act_a, logic [9:0] exp_a,
                       logic act_o, logic exp_o);
    checks++;
    if (act_a !== exp_a || act_o !== exp_o) begin
      errors++;
      $display("FAIL %s: fetch=%03h ovf=%0b expected fetch=%03h ovf=%0b",
               req, act_a, act_o, exp_a, exp_o);
    end
  endtask

  task automatic apply(logic [2:0] o, logic [9:0] im, logic [7:0] al, logic pg);
    op = o; imm_addr = im; alu_res = al; page_bit = pg;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", fetch_addr, 10'h1FF, stk_ovf, 1'b0);

    for (int i = 0; i < NROW; i++) begin
      apply(TBL[i][32:30], TBL[i][29:20], TBL[i][19:12], TBL[i][11]);
      check($sformatf("table row %0d", i), fetch_addr, TBL[i][10:1],
            stk_ovf, TBL[i][0]);
    end

    // R1 R10: reset mid-run clears the sticky flag
    rst = 1'b1;
    apply(3'd0, 10'h000, 8'h00, 1'b0);
    check("R1 R10 reset clears ovf", fetch_addr, 10'h1FF, stk_ovf, 1'b0);
    rst = 1'b0;

    // R11: empty return after reset reloads zeroed entry
    apply(3'd6, 10'h000, 8'h00, 1'b0);
    check("R11 empty return after reset", fetch_addr, 10'h000, stk_ovf, 1'b0);
    apply(3'd0, 10'h000, 8'h00, 1'b0);
    check("R2 step after reset return", fetch_addr, 10'h001, stk_ovf, 1'b0);

    // R5 R8: short call with page 0 then return
    apply(3'd3, 10'h2EE, 8'h00, 1'b0);
    check("R5 short call", fetch_addr, 10'h0EE, stk_ovf, 1'b0);
    apply(3'd7, 10'h000, 8'h00, 1'b1);
    check("R8 return-with-W", fetch_addr, 10'h002, stk_ovf, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule